// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block sits in a streaming display pixel path and paints a small cursor on top of it. Each pixel arrives as a 24-bit RGB value with its x and y coordinates and a valid flag. The block keeps a 64x64 cursor bitmap of 2-bit codes in internal memory, which is loaded through a simple write port. It also takes a screen position, three cursor colours, a 4-bit alpha and a mode select as plain configuration inputs.

For a pixel that falls inside the cursor window, the block reads the code under that pixel and acts on it. Depending on the code and the mode, it passes the background pixel through, blends a cursor colour over it with 16-level alpha, or inverts it. Pixels outside the window pass through untouched. Every result leaves exactly two clocks after its input, and the valid flag and coordinates travel with it.

Pixels are packed with red in bits 23:16, green in bits 15:8 and blue in bits 7:0.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is held and on the first edge after it is released, `validOut` is 0 and `pixOut` is all zeros.
- R2: Every input pixel produces its result exactly 2 clocks later. `validOut`, `xOut` and `yOut` equal `validIn`, `xIn` and `yIn` from 2 clocks earlier.
- R3: A pixel is inside the cursor when `xIn - cfgPosX` and `yIn - cfgPosY`, taken as signed differences, both lie in 0..63. A pixel outside the window is output unchanged.
- R4: A write with `wrEn` high stores `wrData` as the code for cursor row `wrAddr[11:6]` and column `wrAddr[5:0]`. An inside pixel uses the code at row `yIn - cfgPosY` and column `xIn - cfgPosX`.
- R5: Code 2'b00 is transparent in both modes, so the background pixel is output unchanged.
- R6: With `cfgMode` = 0, codes 2'b01, 2'b10 and 2'b11 blend `cfgColour0`, `cfgColour1` and `cfgColour2` respectively over the background.
- R7: With `cfgMode` = 1, codes 2'b01 and 2'b10 blend `cfgColour0` and `cfgColour1`. Code 2'b11 outputs the bitwise complement of every background channel, whatever the alpha.
- R8: Blending computes each 8-bit channel as (a*cursor + (15-a)*background + 7)/15, with integer division and a = `cfgAlpha`. So alpha 15 gives the cursor colour exactly and alpha 0 gives the background exactly.
- R9: The window does not wrap around the coordinate space. With the cursor placed near the largest coordinates it is clipped, and small coordinates stay outside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Bitmap write strobe |
| wrAddr | input | 12 | Bitmap write address: {row, column} |
| wrData | input | 2 | Cursor code to store |
| cfgPosX | input | 12 | Cursor window left column on screen |
| cfgPosY | input | 12 | Cursor window top row on screen |
| cfgMode | input | 1 | 0: three colours + transparent; 1: two colours + transparent + invert |
| cfgColour0 | input | 24 | Cursor colour for code 01 |
| cfgColour1 | input | 24 | Cursor colour for code 10 |
| cfgColour2 | input | 24 | Cursor colour for code 11 in mode 0 |
| cfgAlpha | input | 4 | Cursor opacity, 0 to 15 |
| validIn | input | 1 | Input pixel valid |
| xIn | input | 12 | Input pixel column |
| yIn | input | 12 | Input pixel row |
| pixIn | input | 24 | Input background pixel, RGB888 |
| validOut | output | 1 | Output pixel valid |
| xOut | output | 12 | Output pixel column |
| yOut | output | 12 | Output pixel row |
| pixOut | output | 24 | Output pixel, RGB888 |

## Verification
The assertions assume three things about the inputs. Position, mode, colours and alpha stay fixed while any pixel is still in the two-stage pipe. `validIn` is low while reset is held. The pass-through checks compare the output against the position that is current when the result leaves the pipe. The stimulus meets these assumptions by streaming pixels only in bursts. Each burst is followed by three idle cycles before any configuration change, and the bitmap is loaded only while no pixel is flowing.

// File: rtl/cursor_ovl_pkg.sv
`timescale 1ns/1ps
package cursor_ovl_pkg;

  // Action the datapath applies to the pixel in its second stage
  typedef enum logic [1:0] {
    ACT_PASS   = 2'd0,
    ACT_BLEND  = 2'd1,
    ACT_INVERT = 2'd2
  } ovl_act_e;

  typedef struct packed {
    ovl_act_e   act;
    logic [1:0] colSel;   // 0..2 picks cursor colour 0..2
  } ovl_strobe_t;

  localparam logic [1:0] CODE_CLEAR = 2'b00;
  localparam logic [1:0] CODE_TOP   = 2'b11;

endpackage

// File: rtl/cursor_ctrl.sv
`timescale 1ns/1ps
module cursor_ctrl
  import cursor_ovl_pkg::*;
#(
  parameter int COORD_W  = 12,
  parameter int DIM_LOG2 = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    validIn,
  input  logic [COORD_W-1:0]      xIn,
  input  logic [COORD_W-1:0]      yIn,
  input  logic [COORD_W-1:0]      posX,
  input  logic [COORD_W-1:0]      posY,
  input  logic                    modeInvert,
  input  logic [1:0]              code,
  output logic [2*DIM_LOG2-1:0]   rdAddr,
  output ovl_strobe_t             strobe,
  output logic                    validOut,
  output logic [COORD_W-1:0]      xOut,
  output logic [COORD_W-1:0]      yOut
);

  // Extra top bit keeps the sign, so the window never wraps
  logic [COORD_W:0] dxFull, dyFull;
  logic             inWin;

  always_comb begin
    dxFull = {1'b0, xIn} - {1'b0, posX};
    dyFull = {1'b0, yIn} - {1'b0, posY};
    inWin  = !dxFull[COORD_W] && (dxFull[COORD_W-1:DIM_LOG2] == '0) &&
             !dyFull[COORD_W] && (dyFull[COORD_W-1:DIM_LOG2] == '0);
    rdAddr = {dyFull[DIM_LOG2-1:0], dxFull[DIM_LOG2-1:0]};
  end

  // Stage 1: travels alongside the bitmap read
  logic               valid1, inWin1;
  logic [COORD_W-1:0] x1, y1;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid1 <= 1'b0;
      inWin1 <= 1'b0;
      x1     <= '0;
      y1     <= '0;
    end else begin
      valid1 <= validIn;
      inWin1 <= inWin;
      x1     <= xIn;
      y1     <= yIn;
    end
  end

  // Turn the code into an action under the active mode
  always_comb begin
    strobe.act    = ACT_BLEND;
    strobe.colSel = code - 2'd1;
    if (!inWin1 || code == CODE_CLEAR) begin
      strobe.act    = ACT_PASS;
      strobe.colSel = 2'd0;
    end else if (modeInvert && code == CODE_TOP) begin
      strobe.act    = ACT_INVERT;
      strobe.colSel = 2'd0;
    end
  end

  // Stage 2: outputs aligned with the datapath result
  always_ff @(posedge clk) begin
    if (rst) begin
      validOut <= 1'b0;
      xOut     <= '0;
      yOut     <= '0;
    end else begin
      validOut <= valid1;
      xOut     <= x1;
      yOut     <= y1;
    end
  end

endmodule

// File: rtl/cursor_dp.sv
`timescale 1ns/1ps
module cursor_dp
  import cursor_ovl_pkg::*;
#(
  parameter int CH_W     = 8,
  parameter int ALPHA_W  = 4,
  parameter int DIM_LOG2 = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wrEn,
  input  logic [2*DIM_LOG2-1:0]  wrAddr,
  input  logic [1:0]             wrData,
  input  logic [2*DIM_LOG2-1:0]  rdAddr,
  input  logic [3*CH_W-1:0]      pixIn,
  input  logic [3*CH_W-1:0]      colour0,
  input  logic [3*CH_W-1:0]      colour1,
  input  logic [3*CH_W-1:0]      colour2,
  input  logic [ALPHA_W-1:0]     alpha,
  input  ovl_strobe_t            strobe,
  output logic [1:0]             codeOut,
  output logic [3*CH_W-1:0]      pixOut
);

  localparam int ADDR_W = 2 * DIM_LOG2;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PIX_W  = 3 * CH_W;
  localparam int AMAX   = (1 << ALPHA_W) - 1;
  localparam int PROD_W = CH_W + ALPHA_W + 1;

  logic [1:0]       bitmap [DEPTH];
  logic [PIX_W-1:0] pix1;

  // Bitmap: one write port, registered read
  always_ff @(posedge clk) begin
    if (wrEn) bitmap[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      codeOut <= 2'b00;
      pix1    <= '0;
    end else begin
      codeOut <= bitmap[rdAddr];
      pix1    <= pixIn;
    end
  end

  logic [PIX_W-1:0]   curCol, blendPix, nextPix;
  logic [ALPHA_W-1:0] invAlpha;

  always_comb begin
    case (strobe.colSel)
      2'd0:    curCol = colour0;
      2'd1:    curCol = colour1;
      default: curCol = colour2;
    endcase
    invAlpha = ALPHA_W'(AMAX) - alpha;
  end

  // One rounded blend per colour channel
  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    logic [PROD_W-1:0] acc;
    always_comb begin
      acc = PROD_W'(alpha) * PROD_W'(curCol[ch*CH_W +: CH_W]) +
            PROD_W'(invAlpha) * PROD_W'(pix1[ch*CH_W +: CH_W]) +
            PROD_W'(AMAX / 2);
      blendPix[ch*CH_W +: CH_W] = CH_W'(acc / PROD_W'(AMAX));
    end
  end

  always_comb begin
    case (strobe.act)
      ACT_BLEND:  nextPix = blendPix;
      ACT_INVERT: nextPix = ~pix1;
      default:    nextPix = pix1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pixOut <= '0;
    else     pixOut <= nextPix;
  end

endmodule

// File: rtl/cursor_overlay.sv
`timescale 1ns/1ps
module cursor_overlay
  import cursor_ovl_pkg::*;
#(
  parameter int COORD_W  = 12,
  parameter int CH_W     = 8,
  parameter int ALPHA_W  = 4,
  parameter int DIM_LOG2 = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wrEn,
  input  logic [2*DIM_LOG2-1:0] wrAddr,
  input  logic [1:0]            wrData,
  input  logic [COORD_W-1:0]    cfgPosX,
  input  logic [COORD_W-1:0]    cfgPosY,
  input  logic                  cfgMode,
  input  logic [3*CH_W-1:0]     cfgColour0,
  input  logic [3*CH_W-1:0]     cfgColour1,
  input  logic [3*CH_W-1:0]     cfgColour2,
  input  logic [ALPHA_W-1:0]    cfgAlpha,
  input  logic                  validIn,
  input  logic [COORD_W-1:0]    xIn,
  input  logic [COORD_W-1:0]    yIn,
  input  logic [3*CH_W-1:0]     pixIn,
  output logic                  validOut,
  output logic [COORD_W-1:0]    xOut,
  output logic [COORD_W-1:0]    yOut,
  output logic [3*CH_W-1:0]     pixOut
);

  localparam int ADDR_W = 2 * DIM_LOG2;

  logic [ADDR_W-1:0] rdAddr;
  logic [1:0]        code;
  ovl_strobe_t       strobe;

  cursor_ctrl #(.COORD_W(COORD_W), .DIM_LOG2(DIM_LOG2)) u_ctrl (
    .clk(clk), .rst(rst), .validIn(validIn), .xIn(xIn), .yIn(yIn),
    .posX(cfgPosX), .posY(cfgPosY), .modeInvert(cfgMode), .code(code),
    .rdAddr(rdAddr), .strobe(strobe), .validOut(validOut),
    .xOut(xOut), .yOut(yOut)
  );

  cursor_dp #(.CH_W(CH_W), .ALPHA_W(ALPHA_W), .DIM_LOG2(DIM_LOG2)) u_dp (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .pixIn(pixIn), .colour0(cfgColour0),
    .colour1(cfgColour1), .colour2(cfgColour2), .alpha(cfgAlpha),
    .strobe(strobe), .codeOut(code), .pixOut(pixOut)
  );

endmodule

// File: rtl/cursor_overlay_chk.sv
`timescale 1ns/1ps
module cursor_overlay_chk #(
  parameter int COORD_W  = 12,
  parameter int CH_W     = 8,
  parameter int ALPHA_W  = 4,
  parameter int DIM_LOG2 = 6
) (
  input logic               clk,
  input logic               rst,
  input logic [COORD_W-1:0] cfgPosX,
  input logic [COORD_W-1:0] cfgPosY,
  input logic               cfgMode,
  input logic [ALPHA_W-1:0] cfgAlpha,
  input logic               validIn,
  input logic [COORD_W-1:0] xIn,
  input logic [COORD_W-1:0] yIn,
  input logic [3*CH_W-1:0]  pixIn,
  input logic               validOut,
  input logic [COORD_W-1:0] xOut,
  input logic [COORD_W-1:0] yOut,
  input logic [3*CH_W-1:0]  pixOut
);

  localparam int SPAN = 1 << DIM_LOG2;

  logic [1:0] settle;
  logic       rstQ;

  always_ff @(posedge clk) begin
    rstQ <= rst;
    if (rst)              settle <= 2'd0;
    else if (settle != 2) settle <= settle + 2'd1;
  end

  int  offX, offY;
  logic outWin;
  always_comb begin
    offX   = int'(xOut) - int'(cfgPosX);
    offY   = int'(yOut) - int'(cfgPosY);
    outWin = offX < 0 || offX >= SPAN || offY < 0 || offY >= SPAN;
  end

  // R1: outputs idle on the first edge after reset is released
  always_ff @(posedge clk) begin
    if (!rst && rstQ)
      assert_reset_idle_R1: assert (!validOut && pixOut == '0);
  end

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (rst)
    settle == 2'd2 |-> validOut == $past(validIn, 2));

  assert_coord_delay_R2: assert property (@(posedge clk) disable iff (rst)
    (settle == 2'd2 && validOut) |-> (xOut == $past(xIn, 2) && yOut == $past(yIn, 2)));

  assert_outside_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (settle == 2'd2 && validOut && outWin) |-> pixOut == $past(pixIn, 2));

  assert_alpha_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (settle == 2'd2 && validOut && !cfgMode && cfgAlpha == '0) |-> pixOut == $past(pixIn, 2));

endmodule

bind cursor_overlay cursor_overlay_chk #(
  .COORD_W(COORD_W), .CH_W(CH_W), .ALPHA_W(ALPHA_W), .DIM_LOG2(DIM_LOG2)
) u_chk (.*);

// File: tb/cursor_overlay_bench.sv
`timescale 1ns/1ps
module cursor_overlay_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [11:0] wrAddr = '0;
  logic [1:0]  wrData = '0;
  logic [11:0] posX = 12'd100, posY = 12'd50;
  logic        mode = 1'b0;
  logic [23:0] col0 = 24'hFF2010, col1 = 24'h10E040, col2 = 24'h3050F0;
  logic [3:0]  alpha = 4'd15;
  logic        validIn = 1'b0;
  logic [11:0] xIn = '0, yIn = '0;
  logic [23:0] pixIn = '0;
  logic        validOut;
  logic [11:0] xOut, yOut;
  logic [23:0] pixOut;

  always #2.5 clk = ~clk;

  cursor_overlay u_cursor_overlay (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cfgPosX(posX), .cfgPosY(posY), .cfgMode(mode), .cfgColour0(col0),
    .cfgColour1(col1), .cfgColour2(col2), .cfgAlpha(alpha),
    .validIn(validIn), .xIn(xIn), .yIn(yIn), .pixIn(pixIn),
    .validOut(validOut), .xOut(xOut), .yOut(yOut), .pixOut(pixOut)
  );

  int checks = 0, fails = 0;
  logic [1:0] shadow [4096];
  string phaseTag = "";

  // Expectations for the two pixels in flight
  logic        hv [2];
  logic [11:0] hx [2], hy [2];
  logic [23:0] hp [2];
  string       ht [2];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mix(input int c, input int b, input int a);
    return 8'((a * c + (15 - a) * b + 7) / 15);
  endfunction

  function automatic logic [23:0] blendPix(input logic [23:0] c, input logic [23:0] b);
    logic [23:0] r;
    for (int k = 0; k < 3; k++)
      r[k*8 +: 8] = mix(int'(c[k*8 +: 8]), int'(b[k*8 +: 8]), int'(alpha));
    return r;
  endfunction

  function automatic void model(input logic [11:0] x, input logic [11:0] y,
                                input logic [23:0] bg, output logic [23:0] res,
                                output string tag);
    int dx = int'(x) - int'(posX);
    int dy = int'(y) - int'(posY);
    logic [1:0] c;
    if (dx < 0 || dx > 63 || dy < 0 || dy > 63) begin
      res = bg; tag = "R3"; return;
    end
    c = shadow[dy*64 + dx];
    if (c == 2'b00) begin res = bg; tag = "R5"; return; end
    if (mode && c == 2'b11) begin res = ~bg; tag = "R7"; return; end
    res = blendPix(c == 2'b01 ? col0 : (c == 2'b10 ? col1 : col2), bg);
    if (alpha == 4'd0 || alpha == 4'd15) tag = "R8";
    else tag = mode ? "R7" : "R6";
  endfunction

  // One cycle: check the result due now, then drive the next input
  task automatic step(input logic v, input logic [11:0] x, input logic [11:0] y,
                      input logic [23:0] p, input logic we,
                      input logic [11:0] wa, input logic [1:0] wd);
    logic [23:0] e;
    string t;
    @(negedge clk);
    if (hv[1]) begin
      chk(validOut == 1'b1, "R2", "validOut", 32'(validOut), 32'd1);
      chk(xOut == hx[1] && yOut == hy[1], "R2", "coords",
          {8'd0, xOut, yOut}, {8'd0, hx[1], hy[1]});
      chk(pixOut == hp[1], ht[1], "pixel", 32'(pixOut), 32'(hp[1]));
    end else begin
      chk(validOut == 1'b0, "R2", "validOut idle", 32'(validOut), 32'd0);
    end
    hv[1] = hv[0]; hx[1] = hx[0]; hy[1] = hy[0]; hp[1] = hp[0]; ht[1] = ht[0];
    model(x, y, p, e, t);
    if (phaseTag != "") t = phaseTag;
    hv[0] = v; hx[0] = x; hy[0] = y; hp[0] = e; ht[0] = t;
    validIn = v; xIn = x; yIn = y; pixIn = p;
    wrEn = we; wrAddr = wa; wrData = wd;
    if (we) shadow[wa] = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, 1'b0, '0, '0);
  endtask

  task automatic burst(input int n, input int xlo, input int xspan,
                       input int ylo, input int yspan);
    for (int i = 0; i < n; i++)
      step(($urandom % 8) != 0, 12'(xlo + int'($urandom % xspan)),
           12'(ylo + int'($urandom % yspan)), 24'($urandom), 1'b0, '0, '0);
    idle(3);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 2; i++) begin hv[i] = 1'b0; ht[i] = ""; end
    repeat (4) @(negedge clk);
    // R1: idle outputs while reset is held
    chk(validOut == 1'b0 && pixOut == '0, "R1", "reset outputs",
        {7'd0, validOut, pixOut}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(validOut == 1'b0 && pixOut == '0, "R1", "after release",
        {7'd0, validOut, pixOut}, 32'd0);

    // Load the whole bitmap with random codes (R4)
    for (int a = 0; a < 4096; a++)
      step(1'b0, '0, '0, '0, 1'b1, 12'(a), 2'($urandom));
    idle(2);

    // Random streaming over the window and its surroundings
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 3; k++) begin
        mode  = 1'(m);
        alpha = (k == 0) ? 4'd15 : (k == 1) ? 4'd0 : 4'(1 + $urandom % 14);
        burst(400, 90, 86, 40, 86);
      end
    end

    // R4: directed code at row 3, column 5
    phaseTag = "R4";
    mode = 1'b0; alpha = 4'd15;
    step(1'b0, '0, '0, '0, 1'b1, {6'd3, 6'd5}, 2'b01);
    idle(1);
    step(1'b1, posX + 12'd5, posY + 12'd3, 24'h123456, 1'b0, '0, '0);
    step(1'b0, '0, '0, '0, 1'b1, {6'd3, 6'd5}, 2'b11);
    step(1'b1, posX + 12'd5, posY + 12'd3, 24'h654321, 1'b0, '0, '0);
    idle(3);

    // R3: window edges in both directions
    phaseTag = "R3";
    mode = 1'b1; alpha = 4'd9;
    for (int e = 0; e < 4; e++) begin
      logic [11:0] off = (e == 0) ? 12'hFFF : (e == 1) ? 12'd0 : (e == 2) ? 12'd63 : 12'd64;
      step(1'b1, posX + off, posY + 12'd10, 24'(~$urandom), 1'b0, '0, '0);
      step(1'b1, posX + 12'd10, posY + off, 24'($urandom), 1'b0, '0, '0);
    end
    idle(3);

    // R9: cursor clipped at the far corner, no wrap to small coordinates
    phaseTag = "R9";
    posX = 12'd4070; posY = 12'd4080; alpha = 4'd6;
    idle(1);
    burst(150, 4060, 36, 4070, 26);
    burst(60, 0, 30, 0, 30);
    mode = 1'b0;
    burst(150, 4060, 36, 4070, 26);
    phaseTag = "";

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    checks++; fails++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule